// File: doc/BRIEF.md
# Host Port Mailbox Interrupt Unit

This unit is a small register block that connects an embedded processor's internal bus to a 16-bit external host port. Both sides share one 16-bit mailbox. When one side accesses the mailbox, it raises a notification for the other side and clears its own pending notification. There are no explicit clear registers. The processor can also ring two write-only doorbells, one for each serial engine. Each doorbell raises a flag in a status word that the host can read. The host clears a doorbell flag by reading that doorbell. A single host interrupt output stays high while any host-side notification is pending.

Both ports use single-cycle access strobes in one clock domain. The host side is assumed to be synchronised before it reaches this unit. Every strobe is accepted in the cycle it is high, so there is no back-pressure on either port. Read data is combinational from the address or select that is currently applied. A read strobe takes its side effect at the clock edge that ends the access cycle.

A processor control word enables the two processor interrupts and sets the byte-lane swap on the host data bus. The swap applies in both directions. Two swap bits must agree. If they disagree, no swap is applied and a sticky error bit is set.

Top module: `hpi_mbox_unit`

## Requirements
- R1: After reset, all of the following read as zero: the mailbox, the control word, every flag, `host_irq`, `cpu_irq_rxfull` and `cpu_irq_txempty`. The doorbell flags also reset to zero, by explicit choice.
- R2: When rx-enable (control bit 1) is 1, a host write to the mailbox (`host_sel`=0) sets `cpu_irq_rxfull`. A processor read of the mailbox (address 0xC0C6) clears it.
- R3: When tx-enable (control bit 2) is 1, a host read of the mailbox sets `cpu_irq_txempty`. A processor write to the mailbox clears it.
- R4: A processor write to the mailbox sets the pending flag, which is host status bit 0, and asserts `host_irq`. A host read of the mailbox clears the pending flag.
- R5: A processor write to address 0x0144 sets doorbell 0, which is status bit 3. A write to 0x0148 sets doorbell 1, which is status bit 4. The written data is ignored and the mailbox is not changed. A host read with `host_sel`=2 clears doorbell 0, and a host read with `host_sel`=3 clears doorbell 1.
- R6: `host_irq` is the OR of the pending flag and both doorbell flags. It stays high until all three are cleared.
- R7: If a set event and a clear event hit the same flag in the same cycle, the flag ends up set.
- R8: Control bits 8 and 0 both at 1 exchange the two bytes of host write data and host read data. Both at 0 pass the bytes straight through.
- R9: If a control write has bit 8 different from bit 0, no swap is applied. The write also sets a sticky error bit, read back as control bit 15, which only reset clears.
- R10: When an enable bit is 0, the matching host access does not set the processor interrupt.
- R11: A processor read of address 0xC0C6 returns the last value written to the mailbox. A host write is stored after the swap is undone. If both sides write in the same cycle, the processor value is kept.
- R12: A host read with `host_sel`=1 returns the status word: bit 1 is rx-full, bit 2 is tx-empty, and bits 0, 3 and 4 are as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Processor write strobe, one cycle |
| cpu_rd | input | 1 | Processor read strobe, one cycle |
| cpu_addr | input | 16 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data for `cpu_addr` |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_sel | input | 2 | Host register select: 0 mailbox, 1 status, 2 doorbell 0, 3 doorbell 1 |
| host_wdata | input | 16 | Host write data, before any swap |
| host_rdata | output | 16 | Host read data, after any swap |
| host_irq | output | 1 | Host interrupt |
| cpu_irq_rxfull | output | 1 | Processor receive-full interrupt |
| cpu_irq_txempty | output | 1 | Processor transmit-empty interrupt |

## Verification
On every cycle, the assertions check the following:
- the mailbox flags set and clear after each decoded access;
- `host_irq` rises after any processor mailbox or doorbell write, and stays high while no clearing host read occurs;
- a disabled interrupt never rises;
- the error bit stays sticky;
- the mailbox holds its value when nobody writes it.

Only the bench's scenarios can show the rest:
- the byte order of swapped data in both directions;
- the exact status word layout;
- the data returned on reads;
- the ignored doorbell data;
- the outcome when both ports collide on one flag or on the mailbox.

// File: rtl/hpi_mbox_pkg.sv
`timescale 1ns/1ps
package hpi_mbox_pkg;
  typedef enum logic [1:0] {
    HSEL_MBOX   = 2'd0,
    HSEL_STATUS = 2'd1,
    HSEL_BELL0  = 2'd2,
    HSEL_BELL1  = 2'd3
  } host_sel_e;

  // flag index doubles as host status bit position
  localparam int FLG_PEND  = 0;
  localparam int FLG_RX    = 1;
  localparam int FLG_TX    = 2;
  localparam int FLG_BELL0 = 3;
  localparam int FLG_BELL1 = 4;
  localparam int NUM_FLAGS = 5;

  localparam int CTL_SWAP_LO = 0;
  localparam int CTL_RX_EN   = 1;
  localparam int CTL_TX_EN   = 2;

  typedef struct packed {
    logic swap_hi;
    logic swap_lo;
    logic tx_en;
    logic rx_en;
  } ctrl_t;
endpackage

// File: rtl/hpi_lane_swap.sv
`timescale 1ns/1ps
module hpi_lane_swap #(
  parameter int DATA_W = 16
) (
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] crossed;

  for (genvar i = 0; i < HALF; i++) begin : g_lane
    assign crossed[i]        = din[i+HALF];
    assign crossed[i+HALF]   = din[i];
  end

  assign dout = en ? crossed : din;
endmodule

// File: rtl/hpi_flag_bank.sv
`timescale 1ns/1ps
module hpi_flag_bank #(
  parameter int           N         = 5,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= RESET_VAL[i];
      else if (set[i]) q[i] <= 1'b1;   // set wins over clear
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hpi_ctrl_reg.sv
`timescale 1ns/1ps
module hpi_ctrl_reg
  import hpi_mbox_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  ctrl_t wr_val,
  output ctrl_t ctrl,
  output logic  swap_on,
  output logic  cfg_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      cfg_err <= 1'b0;
    end else if (wr) begin
      ctrl <= wr_val;
      if (wr_val.swap_hi != wr_val.swap_lo) cfg_err <= 1'b1;
    end
  end

  // mismatched pair resolves to straight-through lanes
  assign swap_on = ctrl.swap_hi & ctrl.swap_lo;
endmodule

// File: rtl/hpi_mbox_unit.sv
`timescale 1ns/1ps
module hpi_mbox_unit
  import hpi_mbox_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] ADDR_MBOX  = 16'hC0C6,
  parameter logic [ADDR_W-1:0] ADDR_CTRL  = 16'hC0C8,
  parameter logic [ADDR_W-1:0] ADDR_BELL0 = 16'h0144,
  parameter logic [ADDR_W-1:0] ADDR_BELL1 = 16'h0148
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_irq,
  output logic              cpu_irq_rxfull,
  output logic              cpu_irq_txempty
);
  localparam int HALF = DATA_W / 2;

  host_sel_e hsel;
  assign hsel = host_sel_e'(host_sel);

  // processor decode
  logic cpu_mbox_wr, cpu_mbox_rd, cpu_ctrl_wr, cpu_bell0_wr, cpu_bell1_wr;
  assign cpu_mbox_wr  = cpu_wr && (cpu_addr == ADDR_MBOX);
  assign cpu_mbox_rd  = cpu_rd && (cpu_addr == ADDR_MBOX);
  assign cpu_ctrl_wr  = cpu_wr && (cpu_addr == ADDR_CTRL);
  assign cpu_bell0_wr = cpu_wr && (cpu_addr == ADDR_BELL0);
  assign cpu_bell1_wr = cpu_wr && (cpu_addr == ADDR_BELL1);

  // host decode
  logic host_mbox_wr, host_mbox_rd, host_bell0_rd, host_bell1_rd;
  assign host_mbox_wr  = host_wr && (hsel == HSEL_MBOX);
  assign host_mbox_rd  = host_rd && (hsel == HSEL_MBOX);
  assign host_bell0_rd = host_rd && (hsel == HSEL_BELL0);
  assign host_bell1_rd = host_rd && (hsel == HSEL_BELL1);

  // control word
  ctrl_t ctrl_wval, ctrl;
  logic  swap_on, cfg_err, rx_en, tx_en;
  assign ctrl_wval = '{swap_hi: cpu_wdata[HALF],
                       swap_lo: cpu_wdata[CTL_SWAP_LO],
                       tx_en:   cpu_wdata[CTL_TX_EN],
                       rx_en:   cpu_wdata[CTL_RX_EN]};

  hpi_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cpu_ctrl_wr),
    .wr_val  (ctrl_wval),
    .ctrl    (ctrl),
    .swap_on (swap_on),
    .cfg_err (cfg_err)
  );
  assign rx_en = ctrl.rx_en;
  assign tx_en = ctrl.tx_en;

  // host lane swap, both directions
  logic [DATA_W-1:0] host_wdata_n, host_word;
  hpi_lane_swap #(.DATA_W(DATA_W)) u_swap_in (
    .en (swap_on), .din (host_wdata), .dout (host_wdata_n)
  );
  hpi_lane_swap #(.DATA_W(DATA_W)) u_swap_out (
    .en (swap_on), .din (host_word), .dout (host_rdata)
  );

  // mailbox storage: processor write wins a same-cycle collision
  logic [DATA_W-1:0] mbox_q;
  always_ff @(posedge clk) begin
    if (!rst_n)            mbox_q <= '0;
    else if (cpu_mbox_wr)  mbox_q <= cpu_wdata;
    else if (host_mbox_wr) mbox_q <= host_wdata_n;
  end

  // notification flags
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
  always_comb begin
    flag_set            = '0;
    flag_clr            = '0;
    flag_set[FLG_PEND]  = cpu_mbox_wr;
    flag_clr[FLG_PEND]  = host_mbox_rd;
    flag_set[FLG_RX]    = host_mbox_wr && rx_en;
    flag_clr[FLG_RX]    = cpu_mbox_rd;
    flag_set[FLG_TX]    = host_mbox_rd && tx_en;
    flag_clr[FLG_TX]    = cpu_mbox_wr;
    flag_set[FLG_BELL0] = cpu_bell0_wr;
    flag_clr[FLG_BELL0] = host_bell0_rd;
    flag_set[FLG_BELL1] = cpu_bell1_wr;
    flag_clr[FLG_BELL1] = host_bell1_rd;
  end

  hpi_flag_bank #(.N(NUM_FLAGS), .RESET_VAL('0)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .q     (flag_q)
  );

  assign host_irq        = flag_q[FLG_PEND] | flag_q[FLG_BELL0] | flag_q[FLG_BELL1];
  assign cpu_irq_rxfull  = flag_q[FLG_RX];
  assign cpu_irq_txempty = flag_q[FLG_TX];

  // read paths
  logic [DATA_W-1:0] status_word, ctrl_word;
  assign status_word = {{(DATA_W-NUM_FLAGS){1'b0}}, flag_q};

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CTL_SWAP_LO] = ctrl.swap_lo;
    ctrl_word[CTL_RX_EN]   = ctrl.rx_en;
    ctrl_word[CTL_TX_EN]   = ctrl.tx_en;
    ctrl_word[HALF]        = ctrl.swap_hi;
    ctrl_word[DATA_W-1]    = cfg_err;
  end

  always_comb begin
    case (hsel)
      HSEL_MBOX:   host_word = mbox_q;
      HSEL_STATUS: host_word = status_word;
      default:     host_word = '0;
    endcase
  end

  always_comb begin
    if (cpu_addr == ADDR_MBOX)      cpu_rdata = mbox_q;
    else if (cpu_addr == ADDR_CTRL) cpu_rdata = ctrl_word;
    else                            cpu_rdata = '0;
  end
endmodule

module hpi_mbox_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_mbox_wr,
  input logic              cpu_mbox_rd,
  input logic              cpu_bell_wr,
  input logic              host_mbox_wr,
  input logic              host_mbox_rd,
  input logic              host_bell_rd,
  input logic              rx_en,
  input logic              tx_en,
  input logic              cfg_err,
  input logic              host_irq,
  input logic              cpu_irq_rxfull,
  input logic              cpu_irq_txempty,
  input logic [DATA_W-1:0] mbox_q
);
  p_rx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_mbox_wr && rx_en |=> cpu_irq_rxfull);
  p_rx_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mbox_rd && !(host_mbox_wr && rx_en) |=> !cpu_irq_rxfull);
  p_tx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_mbox_rd && tx_en |=> cpu_irq_txempty);
  p_tx_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mbox_wr && !(host_mbox_rd && tx_en) |=> !cpu_irq_txempty);
  p_irq_mbox_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mbox_wr |=> host_irq);
  p_irq_bell_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_bell_wr |=> host_irq);
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq && !host_mbox_rd && !host_bell_rd |=> host_irq);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  p_rx_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !cpu_irq_rxfull |=> !cpu_irq_rxfull);
  p_tx_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && !cpu_irq_txempty |=> !cpu_irq_txempty);
  p_mbox_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_mbox_wr && !host_mbox_wr |=> $stable(mbox_q));
endmodule

bind hpi_mbox_unit hpi_mbox_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cpu_mbox_wr     (cpu_mbox_wr),
  .cpu_mbox_rd     (cpu_mbox_rd),
  .cpu_bell_wr     (cpu_bell0_wr | cpu_bell1_wr),
  .host_mbox_wr    (host_mbox_wr),
  .host_mbox_rd    (host_mbox_rd),
  .host_bell_rd    (host_bell0_rd | host_bell1_rd),
  .rx_en           (rx_en),
  .tx_en           (tx_en),
  .cfg_err         (cfg_err),
  .host_irq        (host_irq),
  .cpu_irq_rxfull  (cpu_irq_rxfull),
  .cpu_irq_txempty (cpu_irq_txempty),
  .mbox_q          (mbox_q)
);

// File: tb/hpi_mbox_unit_bench.sv
`timescale 1ns/1ps
module hpi_mbox_unit_bench;
  localparam logic [15:0] A_MBOX  = 16'hC0C6;
  localparam logic [15:0] A_CTRL  = 16'hC0C8;
  localparam logic [15:0] A_BELL0 = 16'h0144;
  localparam logic [15:0] A_BELL1 = 16'h0148;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 0, cpu_rd = 0, host_wr = 0, host_rd = 0;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0, host_wdata = '0;
  logic [1:0]  host_sel = '0;
  logic [15:0] cpu_rdata, host_rdata;
  logic host_irq, cpu_irq_rxfull, cpu_irq_txempty;

  always #2.5 clk = ~clk;

  hpi_mbox_unit u_hpi_mbox_unit (
    .clk (clk), .rst_n (rst_n),
    .cpu_wr (cpu_wr), .cpu_rd (cpu_rd), .cpu_addr (cpu_addr),
    .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
    .host_wr (host_wr), .host_rd (host_rd), .host_sel (host_sel),
    .host_wdata (host_wdata), .host_rdata (host_rdata),
    .host_irq (host_irq), .cpu_irq_rxfull (cpu_irq_rxfull),
    .cpu_irq_txempty (cpu_irq_txempty)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expected state, derived from the requirements
  logic [15:0] m_mbox, m_ctrl;
  logic m_err, m_pend, m_rx, m_tx, m_b0, m_b1;

  function automatic logic [15:0] bswap(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  function automatic logic m_swap();
    return m_ctrl[8] & m_ctrl[0];
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_mbox = '0; m_ctrl = '0; m_err = 0;
    m_pend = 0; m_rx = 0; m_tx = 0; m_b0 = 0; m_b1 = 0;
  endtask

  task automatic chk_outs(input string tag);
    chk(tag, "host_irq", {15'd0, host_irq}, {15'd0, m_pend | m_b0 | m_b1});
    chk(tag, "rxfull",   {15'd0, cpu_irq_rxfull},  {15'd0, m_rx});
    chk(tag, "txempty",  {15'd0, cpu_irq_txempty}, {15'd0, m_tx});
  endtask

  task automatic step(input string tag,
                      input logic cw, input logic cr, input logic [15:0] ca,
                      input logic [15:0] cd,
                      input logic hw, input logic hr, input logic [1:0] hs,
                      input logic [15:0] hd);
    logic [15:0] exp_c, exp_h, hword;
    logic n_pend, n_rx, n_tx, n_b0, n_b1;
    @(negedge clk);
    cpu_wr = cw; cpu_rd = cr; cpu_addr = ca; cpu_wdata = cd;
    host_wr = hw; host_rd = hr; host_sel = hs; host_wdata = hd;
    #1;
    exp_c = (ca == A_MBOX) ? m_mbox :
            (ca == A_CTRL) ? (m_ctrl | {m_err, 15'd0}) : 16'h0000;
    case (hs)
      2'd0:    hword = m_mbox;
      2'd1:    hword = {11'd0, m_b1, m_b0, m_tx, m_rx, m_pend};
      default: hword = 16'h0000;
    endcase
    exp_h = m_swap() ? bswap(hword) : hword;
    if (cr) chk(tag, "cpu_rdata", cpu_rdata, exp_c);
    if (hr) chk(tag, "host_rdata", host_rdata, exp_h);
    // next state, set wins over clear
    n_pend = (cw && ca == A_MBOX) ? 1'b1 : (hr && hs == 2'd0) ? 1'b0 : m_pend;
    n_rx   = (hw && hs == 2'd0 && m_ctrl[1]) ? 1'b1 : (cr && ca == A_MBOX) ? 1'b0 : m_rx;
    n_tx   = (hr && hs == 2'd0 && m_ctrl[2]) ? 1'b1 : (cw && ca == A_MBOX) ? 1'b0 : m_tx;
    n_b0   = (cw && ca == A_BELL0) ? 1'b1 : (hr && hs == 2'd2) ? 1'b0 : m_b0;
    n_b1   = (cw && ca == A_BELL1) ? 1'b1 : (hr && hs == 2'd3) ? 1'b0 : m_b1;
    if (cw && ca == A_MBOX)      m_mbox = cd;
    else if (hw && hs == 2'd0)   m_mbox = m_swap() ? bswap(hd) : hd;
    if (cw && ca == A_CTRL) begin
      m_ctrl = cd & 16'h0107;
      if (cd[8] != cd[0]) m_err = 1'b1;
    end
    m_pend = n_pend; m_rx = n_rx; m_tx = n_tx; m_b0 = n_b0; m_b1 = n_b1;
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; host_wr = 0; host_rd = 0;
    #1;
    chk_outs(tag);
  endtask

  task automatic cpu_w(input string tag, input logic [15:0] a, input logic [15:0] d);
    step(tag, 1, 0, a, d, 0, 0, 2'd1, 16'h0);
  endtask
  task automatic cpu_r(input string tag, input logic [15:0] a);
    step(tag, 0, 1, a, 16'h0, 0, 0, 2'd1, 16'h0);
  endtask
  task automatic host_w(input string tag, input logic [1:0] s, input logic [15:0] d);
    step(tag, 0, 0, 16'h0, 16'h0, 1, 0, s, d);
  endtask
  task automatic host_r(input string tag, input logic [1:0] s);
    step(tag, 0, 0, 16'h0, 16'h0, 0, 1, s, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_outs("R1");
    cpu_r("R1", A_MBOX);
    cpu_r("R1", A_CTRL);
    host_r("R1", 2'd1);

    // sweep swap pairs x enable pairs x data patterns
    for (int s = 0; s < 4; s++) begin
      for (int en = 0; en < 4; en++) begin
        logic [15:0] cw;
        cw = {7'd0, s[1], 5'd0, en[1:0], s[0]};
        cpu_w((s == 1 || s == 2) ? "R9" : "R8", A_CTRL, cw);
        cpu_r("R9", A_CTRL);
        for (int k = 0; k < 4; k++) begin
          logic [15:0] p;
          p = 16'(16'h1357 * (k + 1)) ^ 16'(s << 12) ^ 16'(en << 4);
          host_w(en[0] ? "R2" : "R10", 2'd0, p);
          host_r("R12", 2'd1);
          cpu_r("R11", A_MBOX);
          cpu_w("R4", A_MBOX, p ^ 16'h5A3C);
          host_r("R8", 2'd1);
          host_r(en[1] ? "R3" : "R10", 2'd0);
          host_r("R12", 2'd1);
        end
      end
    end

    // doorbells with straight lanes
    cpu_w("R5", A_CTRL, 16'h0006);
    cpu_w("R5", A_MBOX, 16'hBEEF);
    host_r("R5", 2'd0);
    cpu_w("R5", A_BELL0, 16'hFFFF);
    host_r("R5", 2'd1);
    cpu_r("R5", A_MBOX);
    host_r("R5", 2'd2);
    cpu_w("R5", A_BELL1, 16'h0000);
    host_r("R5", 2'd1);
    host_r("R5", 2'd3);
    cpu_w("R5", 16'h0146, 16'h1234);
    host_r("R5", 2'd1);

    // interrupt held until every source is cleared
    cpu_w("R6", A_BELL0, 16'h00A5);
    cpu_w("R6", A_BELL1, 16'h5A00);
    cpu_w("R6", A_MBOX, 16'hC001);
    host_r("R6", 2'd2);
    host_r("R6", 2'd0);
    host_r("R6", 2'd1);
    host_r("R6", 2'd3);

    // same-cycle collisions
    step("R7", 1, 0, A_MBOX, 16'h7777, 0, 1, 2'd0, 16'h0);
    step("R7", 0, 1, A_MBOX, 16'h0, 1, 0, 2'd0, 16'h3C3C);
    step("R7", 1, 0, A_BELL0, 16'h0, 0, 1, 2'd2, 16'h0);
    host_r("R7", 2'd1);
    step("R11", 1, 0, A_MBOX, 16'hAAAA, 1, 0, 2'd0, 16'h5555);
    cpu_r("R11", A_MBOX);
    host_r("R7", 2'd0);
    host_r("R7", 2'd2);
    step("R7", 1, 0, A_MBOX, 16'h0101, 0, 1, 2'd0, 16'h0);
    host_r("R7", 2'd0);

    // sticky error survives a good write, cleared only by reset
    cpu_w("R9", A_CTRL, 16'h0100);
    cpu_w("R9", A_CTRL, 16'h0000);
    cpu_r("R9", A_CTRL);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1;
    chk_outs("R1");
    cpu_r("R1", A_CTRL);
    host_r("R1", 2'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule